// File: doc/BRIEF.md
# I2C Packet Header Decoder

This block sits between a transmit word FIFO and a byte-level I2C bus engine. Every transfer arrives as three header words followed, for a write, by payload words. The block pops the headers, captures the packet id, the byte count and the transfer flags, and then drives the bus engine one byte command at a time. The commands are start, repeated start, stop, write-byte and read-byte.

For a write, the block unpacks payload words into bytes. For a read, it packs the returned bytes into words and pushes them to a receive FIFO. It raises a one-cycle event when a packet completes, when the target fails to acknowledge, or when bus arbitration is lost. After an error it abandons the packet and discards whatever payload is still waiting.

The bus engine accepts a command on a valid/ready handshake. It answers each accepted command with exactly one response pulse that carries the acknowledge status, an arbitration-lost flag and, for reads, the received byte. The decoder keeps at most one command outstanding.

Top module: `i2c_pkt_decoder`

## Requirements
- R1: Each packet consumes three header words in order. In word 0, bits 27:16 hold the packet id, which appears on `evt_id` with the packet's events. In word 1, bits LEN_W-1:0 hold the byte count minus one. In word 2, bits 10:1 hold the target address and bits 22:16 hold the flags: 16 keep-bus, 17 interrupt enable, 18 ten-bit, 19 read, 20 start byte, 21 ignore-nack, 22 high speed.
- R2: Command codes are 0 start, 1 repeated start, 2 stop, 3 write byte, 4 read with ack and 5 read with nack. `cmd_byte` is zero for commands that carry no byte. A command stays valid and stable until accepted, and only one command is outstanding at a time.
- R3: In seven-bit mode the single address byte is address bits 6:0 in bits 7:1, with the direction in bit 0 (1 = read).
- R4: In ten-bit mode the first address byte is 11110, then address bits 9:8, then the direction bit. A second byte carries address bits 7:0.
- R5: Write payload is sent least significant byte first, four bytes per word. Only the low bytes of a final partial word are sent.
- R6: Each read byte is requested with code 4, except the last, which uses code 5. Received bytes fill words from the least significant byte up. A partial last word has its upper bytes set to zero. A word is pushed only while `rx_ready` is high.
- R7: A packet ends with a stop unless the keep-bus flag is set. In that case no stop is sent, and the next packet opens with a repeated start instead of a start.
- R8: With the start-byte flag set, the start is followed by a write of 0x01, whose acknowledge is ignored, and then a repeated start before the address.
- R9: A nack on an address or write-data byte raises `evt_nack`, sends a stop, discards the packet's remaining payload words and returns to idle. With ignore-nack set, the transfer continues and no event is raised.
- R10: Lost arbitration on any response raises `evt_arb`. No further command follows, the remaining payload is discarded, and the next packet opens with a plain start.
- R11: A successful packet raises `evt_done` once. `evt_irq` accompanies it only when the interrupt-enable flag is set. At most one of `evt_done`, `evt_nack` and `evt_arb` is high in any cycle.
- R12: `hs_mode` follows the high-speed flag while a packet's bus commands are in progress and is low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Consume the head word |
| rx_ready | input | 1 | Receive FIFO can take a word |
| rx_push | output | 1 | Write `rx_data` to the receive FIFO |
| rx_data | output | 32 | Packed receive word |
| cmd_valid | output | 1 | Byte command offered |
| cmd_ready | input | 1 | Bus engine takes the command |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte to send |
| rsp_valid | input | 1 | Response to the outstanding command |
| rsp_nack | input | 1 | Target did not acknowledge |
| rsp_arb_lost | input | 1 | Arbitration lost |
| rsp_data | input | 8 | Received byte |
| hs_mode | output | 1 | High-speed transfer active |
| evt_done | output | 1 | Packet complete pulse |
| evt_irq | output | 1 | Completion interrupt pulse |
| evt_nack | output | 1 | Missing acknowledge pulse |
| evt_arb | output | 1 | Arbitration lost pulse |
| evt_id | output | 12 | Packet id of the current packet |

## Verification
The assertions assume that the bus engine answers only a command it has accepted, gives exactly one response per command, and never pairs a response with a new acceptance in the same cycle. The bench's engine model enforces this. It starts a one-to-three-cycle countdown only on a handshake, drives a single response pulse, and injects at most one error kind, either a nack or an arbitration loss, at a chosen command index per packet. Ready signals on both sides stall at random so that the hold and push rules are exercised.

// File: rtl/i2c_pkt_decoder.sv
module i2c_pkt_decoder #(
  parameter int LEN_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_valid,
  input  logic [31:0] tx_data,
  output logic        tx_pop,
  input  logic        rx_ready,
  output logic        rx_push,
  output logic [31:0] rx_data,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  input  logic        rsp_valid,
  input  logic        rsp_nack,
  input  logic        rsp_arb_lost,
  input  logic [7:0]  rsp_data,
  output logic        hs_mode,
  output logic        evt_done,
  output logic        evt_irq,
  output logic        evt_nack,
  output logic        evt_arb,
  output logic [11:0] evt_id
);
  localparam int CNT_W  = LEN_W + 1;
  localparam int WCNT_W = LEN_W - 1;

  localparam logic [2:0] OP_START  = 3'd0;
  localparam logic [2:0] OP_RSTART = 3'd1;
  localparam logic [2:0] OP_STOP   = 3'd2;
  localparam logic [2:0] OP_WRITE  = 3'd3;
  localparam logic [2:0] OP_RDACK  = 3'd4;
  localparam logic [2:0] OP_RDNAK  = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_H1, S_H2, S_START, S_SBYTE, S_SRST, S_ADR1, S_ADR2,
    S_FETCH, S_DATA, S_PUSH, S_END, S_STOP, S_DRAIN
  } state_t;

  state_t            st;
  logic              waiting, held, failed;
  logic [11:0]       id;
  logic [LEN_W-1:0]  len;
  logic [CNT_W-1:0]  cnt;
  logic [WCNT_W-1:0] wpop;
  logic [9:0]        addr;
  logic              rd, ten, cont, sbyte, rep, ie, hs;
  logic [31:0]       word;
  logic [1:0]        bidx;

  logic issuing, rsp_ok, nack_err, last_byte, need_drain, active;
  logic [WCNT_W-1:0] total_words;

  assign issuing     = st inside {S_START, S_SBYTE, S_SRST, S_ADR1, S_ADR2, S_DATA, S_STOP};
  assign cmd_valid   = issuing && !waiting;
  assign rsp_ok      = waiting && rsp_valid;
  assign nack_err    = rsp_nack && !cont;
  assign last_byte   = (cnt == {1'b0, len});
  assign total_words = WCNT_W'(len[LEN_W-1:2]) + WCNT_W'(1);
  assign need_drain  = !rd && (wpop != total_words);
  assign active      = !(st inside {S_IDLE, S_H1, S_H2});
  assign hs_mode     = hs && active;
  assign tx_pop      = tx_valid && (st inside {S_IDLE, S_H1, S_H2, S_FETCH} ||
                                    (st == S_DRAIN && need_drain));
  assign rx_push     = (st == S_PUSH) && rx_ready;
  assign rx_data     = word;
  assign evt_id      = id;

  always_comb begin
    cmd_op   = OP_START;
    cmd_byte = 8'h00;
    case (st)
      S_START: cmd_op = held ? OP_RSTART : OP_START;
      S_SBYTE: begin cmd_op = OP_WRITE; cmd_byte = 8'h01; end
      S_SRST:  cmd_op = OP_RSTART;
      S_ADR1: begin
        cmd_op   = OP_WRITE;
        cmd_byte = ten ? {5'b11110, addr[9:8], rd} : {addr[6:0], rd};
      end
      S_ADR2:  begin cmd_op = OP_WRITE; cmd_byte = addr[7:0]; end
      S_DATA: begin
        if (rd) cmd_op = last_byte ? OP_RDNAK : OP_RDACK;
        else begin
          cmd_op   = OP_WRITE;
          cmd_byte = word[{bidx, 3'b000} +: 8];
        end
      end
      S_STOP:  cmd_op = OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; waiting <= 1'b0; held <= 1'b0; failed <= 1'b0;
      id <= '0; len <= '0; cnt <= '0; wpop <= '0; addr <= '0;
      {rd, ten, cont, sbyte, rep, ie, hs} <= '0;
      word <= '0; bidx <= '0;
      {evt_done, evt_irq, evt_nack, evt_arb} <= '0;
    end else begin
      {evt_done, evt_irq, evt_nack, evt_arb} <= '0;
      if (cmd_valid && cmd_ready) waiting <= 1'b1;
      if (rsp_ok) waiting <= 1'b0;
      if (rsp_ok && rsp_arb_lost) begin
        evt_arb <= 1'b1;
        held    <= 1'b0;
        failed  <= 1'b1;
        st      <= S_DRAIN;
      end else begin
        case (st)
          S_IDLE: if (tx_valid) begin id <= tx_data[27:16]; st <= S_H1; end
          S_H1:   if (tx_valid) begin len <= tx_data[LEN_W-1:0]; st <= S_H2; end
          S_H2: if (tx_valid) begin
            addr  <= tx_data[10:1];
            rep   <= tx_data[16];
            ie    <= tx_data[17];
            ten   <= tx_data[18];
            rd    <= tx_data[19];
            sbyte <= tx_data[20];
            cont  <= tx_data[21];
            hs    <= tx_data[22];
            cnt <= '0; wpop <= '0; bidx <= '0; word <= '0; failed <= 1'b0;
            st <= S_START;
          end
          S_START: if (rsp_ok) begin
            held <= 1'b0;
            st   <= sbyte ? S_SBYTE : S_ADR1;
          end
          S_SBYTE: if (rsp_ok) st <= S_SRST;
          S_SRST:  if (rsp_ok) st <= S_ADR1;
          S_ADR1: if (rsp_ok) begin
            if (nack_err) begin evt_nack <= 1'b1; failed <= 1'b1; st <= S_STOP; end
            else st <= ten ? S_ADR2 : (rd ? S_DATA : S_FETCH);
          end
          S_ADR2: if (rsp_ok) begin
            if (nack_err) begin evt_nack <= 1'b1; failed <= 1'b1; st <= S_STOP; end
            else st <= rd ? S_DATA : S_FETCH;
          end
          S_FETCH: if (tx_valid) begin
            word <= tx_data;
            wpop <= wpop + WCNT_W'(1);
            bidx <= '0;
            st   <= S_DATA;
          end
          S_DATA: if (rsp_ok) begin
            if (rd) begin
              word[{bidx, 3'b000} +: 8] <= rsp_data;
              cnt  <= cnt + CNT_W'(1);
              bidx <= bidx + 2'd1;
              if (last_byte || bidx == 2'd3) st <= S_PUSH;
            end else if (nack_err) begin
              evt_nack <= 1'b1; failed <= 1'b1; st <= S_STOP;
            end else begin
              cnt  <= cnt + CNT_W'(1);
              bidx <= bidx + 2'd1;
              if (last_byte) st <= S_END;
              else if (bidx == 2'd3) st <= S_FETCH;
            end
          end
          S_PUSH: if (rx_ready) begin
            word <= '0;
            bidx <= '0;
            st   <= (cnt == {1'b0, len} + CNT_W'(1)) ? S_END : S_DATA;
          end
          S_END: begin
            if (rep) begin
              held <= 1'b1; evt_done <= 1'b1; evt_irq <= ie; st <= S_IDLE;
            end else st <= S_STOP;
          end
          S_STOP: if (rsp_ok) begin
            held <= 1'b0;
            if (failed) st <= S_DRAIN;
            else begin evt_done <= 1'b1; evt_irq <= ie; st <= S_IDLE; end
          end
          S_DRAIN: begin
            if (tx_pop) wpop <= wpop + WCNT_W'(1);
            if (!need_drain) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);
  a_r11_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_done, evt_nack, evt_arb}));
  a_r11_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |-> evt_done);
  a_r6_push_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
  a_r10_silent_after_arb: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_arb_lost |=> !cmd_valid);
endmodule

// File: tb/test_i2c_pkt_decoder.sv
module test_i2c_pkt_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tx_valid = 1'b0, tx_pop;
  logic [31:0] tx_data = '0;
  logic        rx_ready = 1'b0, rx_push;
  logic [31:0] rx_data;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_arb_lost = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        hs_mode, evt_done, evt_irq, evt_nack, evt_arb;
  logic [11:0] evt_id;

  i2c_pkt_decoder #(.LEN_W(12)) i_i2c_pkt_decoder (
    .clk, .rst_n, .tx_valid, .tx_data, .tx_pop, .rx_ready, .rx_push, .rx_data,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_byte, .rsp_valid, .rsp_nack,
    .rsp_arb_lost, .rsp_data, .hs_mode, .evt_done, .evt_irq, .evt_nack,
    .evt_arb, .evt_id);

  int checks = 0, errors = 0;
  logic [31:0] txq [0:1023];
  int wcnt = 0, rptr = 0;
  logic [10:0] logq [0:127];
  logic        loghs [0:127];
  int nlog = 0;
  logic [31:0] rxq [0:63];
  int nrx = 0;
  int cnt_done = 0, cnt_irq = 0, cnt_nack = 0, cnt_arb = 0;
  logic [11:0] last_id = '0;
  int nack_at = 999, arb_at = 999, rwait = 0, ridx = 0;
  bit pop_pend = 1'b0;
  bit exp_held = 1'b0;

  function automatic logic [7:0] rdbyte(input int i);
    return 8'(i * 29 + 91);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_pend) rptr++;
      rsp_valid = 1'b0;
      if (rwait > 0) begin
        rwait--;
        if (rwait == 0) begin
          rsp_valid    = 1'b1;
          rsp_nack     = (ridx == nack_at);
          rsp_arb_lost = (ridx == arb_at);
          rsp_data     = rdbyte(ridx);
        end
      end
      tx_valid  = (rptr < wcnt);
      tx_data   = (rptr < wcnt) ? txq[rptr] : 32'h0;
      cmd_ready = ($urandom % 4) != 0;
      rx_ready  = ($urandom % 3) != 0;
      #1;
      pop_pend = tx_pop;
      if (rx_push) begin rxq[nrx] = rx_data; nrx++; end
      if (cmd_valid && cmd_ready) begin
        logq[nlog]  = {cmd_op, cmd_byte};
        loghs[nlog] = hs_mode;
        ridx = nlog;
        nlog++;
        rwait = 1 + ($urandom % 3);
      end
      if (evt_done) begin cnt_done++; last_id = evt_id; end
      if (evt_irq)  cnt_irq++;
      if (evt_nack) cnt_nack++;
      if (evt_arb)  cnt_arb++;
    end
  end

  task automatic run_pkt(input int len, input logic [9:0] addr, input bit ten,
                         input bit rd, input bit cont, input bit sb, input bit rep,
                         input bit ie, input bit hs, input int nk, input int ab,
                         input logic [11:0] id);
    logic [10:0] p_op [0:63];
    bit          p_sens [0:63];
    string       p_tag [0:63];
    logic [10:0] e_op [0:63];
    string       e_tag [0:63];
    logic [7:0]  pay [0:15];
    int pn = 0, en = 0, res = 0, ds, t, d0, i0, n0, a0;
    logic [7:0] a1;
    @(negedge clk); #2;
    nlog = 0; nrx = 0; nack_at = nk; arb_at = ab;
    d0 = cnt_done; i0 = cnt_irq; n0 = cnt_nack; a0 = cnt_arb;
    for (int k = 0; k < 16; k++) pay[k] = 8'($urandom);
    txq[wcnt] = (32'(id) << 16) | 32'h10; wcnt++;
    txq[wcnt] = 32'(len - 1); wcnt++;
    txq[wcnt] = {9'b0, hs, cont, sb, rd, ten, ie, rep, 5'b0, addr, 1'b0}; wcnt++;
    if (!rd) begin
      for (int w = 0; w < (len + 3) / 4; w++) begin
        logic [31:0] v = $urandom;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < len) v[b*8 +: 8] = pay[w*4 + b];
        txq[wcnt] = v; wcnt++;
      end
    end
    p_op[pn] = {exp_held ? 3'd1 : 3'd0, 8'h00}; p_sens[pn] = 0; p_tag[pn] = "R7 open"; pn++;
    if (sb) begin
      p_op[pn] = {3'd3, 8'h01}; p_sens[pn] = 0; p_tag[pn] = "R8 start byte"; pn++;
      p_op[pn] = {3'd1, 8'h00}; p_sens[pn] = 0; p_tag[pn] = "R8 restart"; pn++;
    end
    a1 = ten ? {5'b11110, addr[9:8], rd} : {addr[6:0], rd};
    p_op[pn] = {3'd3, a1}; p_sens[pn] = 1; p_tag[pn] = ten ? "R4 addr hi" : "R3 addr"; pn++;
    if (ten) begin p_op[pn] = {3'd3, addr[7:0]}; p_sens[pn] = 1; p_tag[pn] = "R4 addr lo"; pn++; end
    ds = pn;
    for (int k = 0; k < len; k++) begin
      if (rd) begin p_op[pn] = {(k == len - 1) ? 3'd5 : 3'd4, 8'h00}; p_sens[pn] = 0; p_tag[pn] = "R6 read cmd"; end
      else begin p_op[pn] = {3'd3, pay[k]}; p_sens[pn] = 1; p_tag[pn] = "R5 write byte"; end
      pn++;
    end
    if (!rep) begin p_op[pn] = {3'd2, 8'h00}; p_sens[pn] = 0; p_tag[pn] = "R7 stop"; pn++; end
    for (int i = 0; i < pn; i++) begin
      e_op[en] = p_op[i]; e_tag[en] = p_tag[i]; en++;
      if (i == ab) begin res = 2; break; end
      if (p_sens[i] && i == nk && !cont) begin
        e_op[en] = {3'd2, 8'h00}; e_tag[en] = "R9 stop after nack"; en++;
        res = 1; break;
      end
    end
    t = 0;
    while (cnt_done == d0 && cnt_nack == n0 && cnt_arb == a0 && t < 4000) begin
      @(negedge clk); t++;
    end
    chk(t < 4000, "R11", "packet end seen", t, 0);
    repeat (60) @(negedge clk);
    chk(nlog == en, "R2", "command count", nlog, en);
    for (int i = 0; i < en && i < nlog; i++) begin
      chk(logq[i] == e_op[i], e_tag[i], "command", logq[i], e_op[i]);
      chk(loghs[i] == hs, "R12", "hs_mode during packet", loghs[i], hs);
    end
    chk(cnt_done - d0 == (res == 0 ? 1 : 0), "R11", "done events", cnt_done - d0, res == 0);
    chk(cnt_irq - i0 == ((res == 0 && ie) ? 1 : 0), "R11", "irq events", cnt_irq - i0, res == 0 && ie);
    chk(cnt_nack - n0 == (res == 1 ? 1 : 0), "R9", "nack events", cnt_nack - n0, res == 1);
    chk(cnt_arb - a0 == (res == 2 ? 1 : 0), "R10", "arb events", cnt_arb - a0, res == 2);
    chk(rptr == wcnt, "R9", "all words consumed", rptr, wcnt);
    chk(hs_mode == 1'b0, "R12", "hs_mode idle", hs_mode, 0);
    if (res == 0) chk(last_id == id, "R1", "packet id", last_id, id);
    if (rd && res == 0) begin
      chk(nrx == (len + 3) / 4, "R6", "rx word count", nrx, (len + 3) / 4);
      for (int w = 0; w < (len + 3) / 4 && w < nrx; w++) begin
        logic [31:0] v = '0;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < len) v[b*8 +: 8] = rdbyte(ds + w * 4 + b);
        chk(rxq[w] == v, "R6", "rx word", rxq[w], v);
      end
    end
    exp_held = (res == 0) && rep;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(cmd_valid == 0 && rx_push == 0 && tx_pop == 0, "R2", "reset idle outputs",
        {cmd_valid, rx_push, tx_pop}, 0);
    chk({evt_done, evt_irq, evt_nack, evt_arb, hs_mode} == 0, "R11", "reset events",
        {evt_done, evt_irq, evt_nack, evt_arb, hs_mode}, 0);
    run_pkt(5, 10'h050, 0, 0, 0, 0, 0, 0, 0, 999, 999, 12'h101);
    run_pkt(6, 10'h2A5, 1, 1, 0, 0, 0, 1, 0, 999, 999, 12'h202);
    run_pkt(8, 10'h033, 0, 0, 0, 0, 0, 1, 0, 1, 999, 12'h303);
    run_pkt(6, 10'h044, 0, 0, 1, 0, 0, 0, 0, 3, 999, 12'h404);
    run_pkt(9, 10'h155, 1, 0, 0, 0, 0, 0, 1, 999, 4, 12'h505);
    run_pkt(2, 10'h066, 0, 0, 0, 0, 1, 1, 0, 999, 999, 12'h606);
    run_pkt(3, 10'h077, 0, 1, 0, 0, 0, 0, 0, 999, 999, 12'h707);
    run_pkt(1, 10'h012, 0, 0, 0, 1, 0, 0, 1, 1, 999, 12'h808);
    run_pkt(4, 10'h3FF, 1, 1, 0, 0, 0, 0, 0, 999, 999, 12'h909);
    run_pkt(1, 10'h07F, 0, 1, 0, 0, 1, 0, 0, 999, 999, 12'hA0A);
    run_pkt(5, 10'h21C, 1, 0, 0, 0, 0, 0, 0, 2, 999, 12'hB0B);
    for (int n = 0; n < 40; n++) begin
      int len = 1 + ($urandom % 16);
      int mode = $urandom % 4;
      int nk = (mode == 1) ? int'($urandom % (len + 6)) : 999;
      int ab = (mode == 2) ? int'($urandom % (len + 6)) : 999;
      run_pkt(len, 10'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
              nk, ab, 12'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule